// File: doc/BRIEF.md
# Memory Page Fault Detector

This block sits beside an external memory bus and judges each bus cycle. It decides whether the access may stay in the page that a page-mode memory already has open. For every valid cycle it compares the address, the two space-select lines and the bus-ownership level with those of the previous valid cycle. It then drives an active-low page-hit strobe and a fault flag.

A small configuration register sets which differences count as faults: an address that does not follow on, a change of bus owner, and a change on either space-select line. Each difference has its own enable. The same register also selects which memory spaces are watched. Cycles in a space that is not watched leave the strobe deasserted. The memory controller reads the strobe during the clock that follows the cycle's sampling edge and keeps the page open only when the strobe is low.

Top module: `mem_page_watch`

## Requirements
- R1: After reset, pageHitN is 1, pageFault is 0 and the configuration register reads back as 0.
- R2: The configuration register is written through cfgWrEn and cfgWrData and reads back on cfgRdData. Its fields are: bit 0 address-sequence check, bit 1 bus-owner check, bit 2 sel-line-0 check, bit 3 sel-line-1 check, bit 4 watch program space, bit 5 watch Y data space, bit 6 watch X data space. Bit 7 is reserved and always reads 0.
- R3: cycSpace encodes program as 0, Y data as 1 and X data as 2. Code 3 is never watched. A valid cycle in a space that is not watched gives pageHitN=1 and pageFault=0.
- R4: The first valid cycle after reset is a fault when its space is watched, whatever the check enables are.
- R5: With the address-sequence check on, a watched cycle faults unless its address equals the previous valid cycle's address plus one, modulo 2^ADDR_W. The step from all-ones to zero counts as sequential.
- R6: With the address-sequence check off, an address jump never causes a fault.
- R7: With the bus-owner check on, a change of busMaster since the previous valid cycle is a fault. With the check off, such a change is ignored.
- R8: Each sel line has its own check. A change on cycSel[0] faults only when bit 2 is set, and a change on cycSel[1] faults only when bit 3 is set.
- R9: The reference state (address, sel lines, owner) is taken from every valid cycle, watched or not.
- R10: Both outputs are registered. They show the result of the cycle sampled at a clock edge throughout the following clock, and pageHitN equals pageFault for a watched cycle. A clock with cycValid low is followed by pageHitN=1 and pageFault=0.
- R11: With several checks enabled, a difference in any one enabled class alone is enough to cause a fault, and a cycle with no enabled difference is a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgWrData | input | 8 | Configuration write value |
| cfgRdData | output | 8 | Configuration read value |
| cycValid | input | 1 | A bus cycle is presented this clock |
| cycSpace | input | 2 | Memory space of the cycle |
| cycAddr | input | ADDR_W | Cycle address |
| cycSel | input | 2 | Space-select lines of the cycle |
| busMaster | input | 1 | Current bus-owner level |
| pageHitN | output | 1 | Active-low page-hit strobe |
| pageFault | output | 1 | Fault detected on a watched cycle |

## Verification
The bench builds the block with ADDR_W=8 instead of the default 16. With eight address bits, the wrap from 0xFF to 0x00 can be reached with short directed address values, so the modulo rule of the sequence check is covered without long address walks. Every other behaviour is independent of the address width, so the narrower build loses no coverage of the fault classes, the space gating or the reset state.

// File: rtl/mpw_pkg.sv
package mpw_pkg;
  localparam int CFG_W = 8;
  localparam int SEL_W = 2;

  typedef enum logic [1:0] {
    SPACE_PROG  = 2'd0,
    SPACE_YDATA = 2'd1,
    SPACE_XDATA = 2'd2,
    SPACE_NONE  = 2'd3
  } space_e;

  // Configuration layout, msb first: bit 7 reserved ... bit 0 sequence check
  typedef struct packed {
    logic rsvd;
    logic xOn;
    logic yOn;
    logic pOn;
    logic sel1Chk;
    logic sel0Chk;
    logic mastChk;
    logic seqChk;
  } cfg_t;

  // Control -> datapath strobes
  typedef struct packed {
    logic capture;
  } strobe_t;

  // Datapath -> control comparison results
  typedef struct packed {
    logic             noHistory;
    logic             addrJump;
    logic             mastFlip;
    logic [SEL_W-1:0] selFlip;
  } diff_t;
endpackage

// File: rtl/mpw_datapath.sv
module mpw_datapath
  import mpw_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic [SEL_W-1:0]  cycSel,
  input  logic              busMaster,
  output diff_t             diff
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] nextAddr;   // previous address plus one, kept precomputed
  logic [SEL_W-1:0]  prevSel;
  logic              prevMaster;
  logic              histValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextAddr   <= '0;
      prevSel    <= '0;
      prevMaster <= 1'b0;
      histValid  <= 1'b0;
    end else if (strobes.capture) begin
      nextAddr   <= cycAddr + ADDR_ONE;
      prevSel    <= cycSel;
      prevMaster <= busMaster;
      histValid  <= 1'b1;
    end
  end

  assign diff.noHistory = !histValid;
  assign diff.addrJump  = (cycAddr != nextAddr);
  assign diff.mastFlip  = (busMaster != prevMaster);

  for (genvar i = 0; i < SEL_W; i++) begin : g_selCmp
    assign diff.selFlip[i] = cycSel[i] ^ prevSel[i];
  end

  // R9: every captured cycle becomes the reference for the next one
  a_r9_capture_ref: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (nextAddr == $past(cycAddr) + ADDR_ONE) && histValid);

  a_r9_hold_ref: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(nextAddr) && $stable(prevSel) && $stable(prevMaster));
endmodule

// File: rtl/mpw_control.sv
module mpw_control
  import mpw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic             cycValid,
  input  logic [1:0]       cycSpace,
  input  diff_t            diff,
  output strobe_t          strobes,
  output logic             pageHitN,
  output logic             pageFault
);
  cfg_t   cfg;
  space_e space;
  logic   spaceOn;
  logic   faultNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (cfgWrEn) begin
      cfg      <= cfg_t'(cfgWrData);
      cfg.rsvd <= 1'b0;
    end
  end

  assign cfgRdData = cfg;
  assign space     = space_e'(cycSpace);

  always_comb begin
    unique case (space)
      SPACE_PROG:  spaceOn = cfg.pOn;
      SPACE_YDATA: spaceOn = cfg.yOn;
      SPACE_XDATA: spaceOn = cfg.xOn;
      default:     spaceOn = 1'b0;
    endcase
  end

  assign faultNow = diff.noHistory
                  | (cfg.seqChk  & diff.addrJump)
                  | (cfg.mastChk & diff.mastFlip)
                  | (cfg.sel0Chk & diff.selFlip[0])
                  | (cfg.sel1Chk & diff.selFlip[1]);

  assign strobes.capture = cycValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageHitN  <= 1'b1;
      pageFault <= 1'b0;
    end else if (cycValid && spaceOn) begin
      pageHitN  <= faultNow;
      pageFault <= faultNow;
    end else begin
      pageHitN  <= 1'b1;
      pageFault <= 1'b0;
    end
  end

  a_r2_cfg_readback: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgRdData[CFG_W-2:0] == $past(cfgWrData[CFG_W-2:0]));

  a_r3_unwatched_space: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && !spaceOn) |=> pageHitN && !pageFault);

  a_r4_first_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && spaceOn && diff.noHistory) |=> pageFault);

  a_r6_no_checks_no_fault: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && !diff.noHistory && cfgRdData[3:0] == 4'b0000) |=> !pageFault);

  a_r10_idle_release: assert property (@(posedge clk) disable iff (!rstN)
    !cycValid |=> pageHitN && !pageFault);

  a_r10_hit_no_fault: assert property (@(posedge clk) disable iff (!rstN)
    !pageHitN |-> !pageFault);
endmodule

// File: rtl/mem_page_watch.sv
module mem_page_watch
  import mpw_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              cycValid,
  input  logic [1:0]        cycSpace,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic [1:0]        cycSel,
  input  logic              busMaster,
  output logic              pageHitN,
  output logic              pageFault
);
  strobe_t strobes;
  diff_t   diff;

  mpw_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .cycValid  (cycValid),
    .cycSpace  (cycSpace),
    .diff      (diff),
    .strobes   (strobes),
    .pageHitN  (pageHitN),
    .pageFault (pageFault)
  );

  mpw_datapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cycAddr   (cycAddr),
    .cycSel    (cycSel),
    .busMaster (busMaster),
    .diff      (diff)
  );
endmodule

// File: tb/tb_mem_page_watch.sv
module tb_mem_page_watch;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [7:0]    cfgWrData = '0;
  logic [7:0]    cfgRdData;
  logic          cycValid = 1'b0;
  logic [1:0]    cycSpace = '0;
  logic [AW-1:0] cycAddr = '0;
  logic [1:0]    cycSel = '0;
  logic          busMaster = 1'b0;
  logic          pageHitN;
  logic          pageFault;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 4 ns period

  mem_page_watch #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .cycValid(cycValid), .cycSpace(cycSpace),
    .cycAddr(cycAddr), .cycSel(cycSel), .busMaster(busMaster),
    .pageHitN(pageHitN), .pageFault(pageFault)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic setCfg(input logic [7:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // Present one cycle, then check both outputs during the following clock
  task automatic cyc(input logic [1:0] sp, input logic [AW-1:0] a,
                     input logic [1:0] s, input logic m,
                     input bit watched, input bit flt, input string tag);
    @(negedge clk);
    cycValid = 1'b1; cycSpace = sp; cycAddr = a; cycSel = s; busMaster = m;
    @(negedge clk);
    cycValid = 1'b0;
    check({tag, " pageHitN"},  int'(pageHitN),  watched ? int'(flt) : 1);
    check({tag, " pageFault"}, int'(pageFault), int'(watched && flt));
  endtask

  task automatic t_reset();
    check("R1 pageHitN",  int'(pageHitN), 1);
    check("R1 pageFault", int'(pageFault), 0);
    check("R1 cfg",       int'(cfgRdData), 0);
  endtask

  task automatic t_cfg();
    setCfg(8'hFF);
    check("R2 reserved bit reads 0", int'(cfgRdData), 8'h7F);
    setCfg(8'h2A);
    check("R2 readback", int'(cfgRdData), 8'h2A);
    setCfg(8'h00);
    check("R2 clear", int'(cfgRdData), 8'h00);
  endtask

  task automatic t_first();
    setCfg(8'h10);
    cyc(2'd0, 8'h05, 2'b00, 1'b0, 1, 1, "R4 first cycle");
    cyc(2'd0, 8'h09, 2'b00, 1'b0, 1, 0, "R6 jump ignored");
  endtask

  task automatic t_seq();
    setCfg(8'h11);
    cyc(2'd0, 8'h0A, 2'b00, 1'b0, 1, 0, "R5 sequential");
    cyc(2'd0, 8'h0C, 2'b00, 1'b0, 1, 1, "R5 jump");
    cyc(2'd0, 8'h0D, 2'b00, 1'b0, 1, 0, "R5 sequential again");
    cyc(2'd0, 8'hFF, 2'b00, 1'b0, 1, 1, "R5 jump to top");
    cyc(2'd0, 8'h00, 2'b00, 1'b0, 1, 0, "R5 wrap");
    setCfg(8'h10);
    cyc(2'd0, 8'h40, 2'b00, 1'b0, 1, 0, "R6 check off");
  endtask

  task automatic t_mast();
    setCfg(8'h12);
    cyc(2'd0, 8'h41, 2'b00, 1'b1, 1, 1, "R7 owner change");
    cyc(2'd0, 8'h80, 2'b00, 1'b1, 1, 0, "R7 owner steady");
    setCfg(8'h10);
    cyc(2'd0, 8'h81, 2'b00, 1'b0, 1, 0, "R7 check off");
  endtask

  task automatic t_sel();
    setCfg(8'h14);
    cyc(2'd0, 8'h90, 2'b01, 1'b0, 1, 1, "R8 sel0 change");
    cyc(2'd0, 8'h20, 2'b11, 1'b0, 1, 0, "R8 sel1 change ignored");
    setCfg(8'h18);
    cyc(2'd0, 8'h21, 2'b01, 1'b0, 1, 1, "R8 sel1 change");
    cyc(2'd0, 8'h70, 2'b00, 1'b0, 1, 0, "R8 sel0 change ignored");
  endtask

  task automatic t_space();
    setCfg(8'h20);
    cyc(2'd0, 8'h10, 2'b00, 1'b0, 0, 0, "R3 program unwatched");
    cyc(2'd1, 8'h11, 2'b00, 1'b0, 1, 0, "R3 Y watched");
    cyc(2'd2, 8'h12, 2'b00, 1'b0, 0, 0, "R3 X unwatched");
    setCfg(8'h40);
    cyc(2'd2, 8'h13, 2'b00, 1'b0, 1, 0, "R3 X watched");
    cyc(2'd3, 8'h14, 2'b00, 1'b0, 0, 0, "R3 code 3");
    setCfg(8'h70);
    cyc(2'd3, 8'h15, 2'b00, 1'b0, 0, 0, "R3 code 3 all on");
  endtask

  task automatic t_hist();
    setCfg(8'h21);
    cyc(2'd0, 8'h30, 2'b00, 1'b0, 0, 0, "R9 unwatched ref");
    cyc(2'd1, 8'h31, 2'b00, 1'b0, 1, 0, "R9 follows unwatched");
    cyc(2'd1, 8'h33, 2'b00, 1'b0, 1, 1, "R9 jump");
  endtask

  task automatic t_combo();
    setCfg(8'h1F);
    cyc(2'd0, 8'h34, 2'b00, 1'b0, 1, 0, "R11 all steady");
    cyc(2'd0, 8'h35, 2'b00, 1'b1, 1, 1, "R11 owner only");
    cyc(2'd0, 8'h36, 2'b00, 1'b1, 1, 0, "R11 steady");
    cyc(2'd0, 8'h37, 2'b10, 1'b1, 1, 1, "R11 sel1 only");
    cyc(2'd0, 8'h50, 2'b10, 1'b1, 1, 1, "R11 address only");
  endtask

  task automatic t_idle();
    setCfg(8'h10);
    cyc(2'd0, 8'h51, 2'b10, 1'b1, 1, 0, "R10 hit");
    @(negedge clk);
    check("R10 idle pageHitN",  int'(pageHitN), 1);
    check("R10 idle pageFault", int'(pageFault), 0);
    // reset again: reference is dropped and the first cycle faults
    rstN = 1'b0;
    @(negedge clk);
    t_reset();
    rstN = 1'b1;
    setCfg(8'h10);
    cyc(2'd0, 8'h52, 2'b10, 1'b1, 1, 1, "R4 first after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_cfg();
    t_first();
    t_seq();
    t_mast();
    t_sel();
    t_space();
    t_hist();
    t_combo();
    t_idle();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule